// File: doc/BRIEF.md
# Dual-Mode AGC Loop Filter

This block closes the gain loop of an automatic gain control. Each cycle it may receive one signal-magnitude sample. It compares the sample with a programmable threshold and folds a scaled version of the error into an accumulated gain word. That gain word drives a multiplier elsewhere in the data path. A magnitude below the threshold raises the gain, and a magnitude above it lowers the gain.

The block has two settling modes. In mean mode the signed difference is scaled and added, so the loop approaches its final gain asymptotically. In median mode only the sign of the difference is used. The sign picks a fixed step of plus or minus 1024, which makes the settling time independent of signal level. The scale factor is one of two loop gains, selected by a pin. Each loop gain is a 4-bit mantissa and a 4-bit exponent. A typical setup uses one gain for fast acquisition at the start of a burst and the other for fine tracking.

After every update the accumulator is clamped between two programmable limits. Two clear inputs exist. The sync clear always empties the accumulator. The soft clear empties it only when the keep option is off.

Top module: `agc_loop_filter`

## Requirements
- R1: While `rst` is high at a rising edge, `gain_out` becomes 0 at that edge.
- R2: When `mag_valid` is low and no clear is active, `gain_out` keeps its value.
- R3: In mean mode (`median_mode`=0), a valid sample changes the gain by floor(((threshold - mag) * M) / 2^(15-E)). The result is visible on `gain_out` one cycle after the sample.
- R4: In median mode (`median_mode`=1), the error is +1024 when mag <= threshold (equality counts as positive) and -1024 when mag > threshold. This error is scaled as in R3.
- R5: `loop_gains[7:0]` holds gain 0 and `loop_gains[15:8]` holds gain 1. Within each byte, bits [3:0] are the mantissa M and bits [7:4] are the exponent E. `gain_sel`=0 picks gain 0 and `gain_sel`=1 picks gain 1.
- R6: E=15 applies no shift and E=0 applies a 15-bit arithmetic right shift. The shift rounds toward minus infinity. M=0 leaves the gain unchanged.
- R7: After an update, `gain_out` is clamped to [`gain_lo`, `gain_hi`] and never wraps.
- R8: A high `sync_clr` clears `gain_out` to 0 at the next edge. This holds whatever the state of `soft_clr_keep` and takes priority over a valid sample.
- R9: A high `soft_clr` clears `gain_out` to 0 when `soft_clr_keep`=0. When `soft_clr_keep`=1, `soft_clr` has no effect and a valid sample in the same cycle updates normally.
- R10: In median mode, the largest change per sample is 15*1024 = 15360 (M=15, E=15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_clr | input | 1 | Unconditional accumulator clear |
| soft_clr | input | 1 | Accumulator clear that can be masked |
| soft_clr_keep | input | 1 | 1: ignore `soft_clr` |
| median_mode | input | 1 | 1: sign-only fixed step; 0: proportional |
| gain_sel | input | 1 | Loop gain select |
| loop_gains | input | 16 | Two packed loop gains (see R5) |
| threshold | input | MAG_W | Magnitude target |
| gain_hi | input | ACC_W | Upper gain limit |
| gain_lo | input | ACC_W | Lower gain limit |
| mag_valid | input | 1 | Sample strobe |
| mag | input | MAG_W | Unsigned signal magnitude |
| gain_out | output | ACC_W | Registered accumulated gain |

## Verification
The hardest situations to reach are those where several effects meet in one cycle. Examples are a soft clear that is masked by the keep option while a valid sample arrives, and an update that would carry the gain past a limit. The stimulus uses the largest median step (M=15, E=15) to drive the gain into a narrow window from both sides. It then aligns the clear inputs with valid samples in both keep settings. A long randomized phase varies mode, gain select, the exponent extremes, the limits and the clears together. A behavioural model follows every clock.

// File: rtl/agc_pkg.sv
package agc_pkg;

    localparam int MAN_W     = 4;
    localparam int EXP_W     = 4;
    localparam int LG_W      = MAN_W + EXP_W;
    localparam int NUM_GAINS = 2;
    localparam int SEL_W     = $clog2(NUM_GAINS);
    localparam int MED_W     = 13;

    // fixed median-mode errors: +1024 and -1024 in 13-bit two's complement
    localparam logic [MED_W-1:0] MED_STEP_UP = 13'b0010000000000;
    localparam logic [MED_W-1:0] MED_STEP_DN = 13'b1110000000000;

    typedef struct packed {
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] mant;
    } loop_gain_t;

    typedef enum logic {
        SETTLE_MEAN   = 1'b0,
        SETTLE_MEDIAN = 1'b1
    } settle_mode_t;

    typedef enum logic [1:0] {
        ACC_HOLD  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_CLEAR = 2'd2
    } acc_op_t;

    // right-shift amount for an exponent code: (2^EXP_W - 1) - E
    function automatic logic [EXP_W-1:0] shift_of(input logic [EXP_W-1:0] e);
        return ~e;
    endfunction

endpackage

// File: rtl/agc_err_gen.sv
module agc_err_gen
    import agc_pkg::*;
#(
    parameter int MAG_W = 12,
    localparam int ERR_W = MAG_W + 1
) (
    input  settle_mode_t            mode,
    input  logic [MAG_W-1:0]        thr,
    input  logic [MAG_W-1:0]        mag,
    output logic signed [ERR_W-1:0] err
);

    logic signed [ERR_W-1:0] diff;
    logic signed [ERR_W-1:0] step_up;
    logic signed [ERR_W-1:0] step_dn;
    logic                    at_or_below;

    assign diff        = $signed({1'b0, thr}) - $signed({1'b0, mag});
    assign at_or_below = (mag <= thr);

    // fixed steps are sign-extended into the error width (MAG_W >= 12 expected)
    assign step_up = ERR_W'($signed(MED_STEP_UP));
    assign step_dn = ERR_W'($signed(MED_STEP_DN));

    always_comb begin
        unique case (mode)
            SETTLE_MEDIAN: err = at_or_below ? step_up : step_dn;
            default:       err = diff;
        endcase
    end

endmodule

// File: rtl/agc_gain_scale.sv
module agc_gain_scale
    import agc_pkg::*;
#(
    parameter int ERR_W = 13,
    parameter int ACC_W = 20,
    localparam int PROD_W = ERR_W + MAN_W + 1,
    localparam int OUT_W  = ACC_W + 2
) (
    input  logic [NUM_GAINS*LG_W-1:0] loop_gains,
    input  logic [SEL_W-1:0]          gain_sel,
    input  logic signed [ERR_W-1:0]   err,
    output logic signed [OUT_W-1:0]   delta
);

    loop_gain_t slot [NUM_GAINS];

    for (genvar g = 0; g < NUM_GAINS; g++) begin : g_slot
        assign slot[g] = loop_gain_t'(loop_gains[g*LG_W +: LG_W]);
    end

    loop_gain_t              sel;
    logic [EXP_W-1:0]        sh;
    logic signed [PROD_W-1:0] err_x;
    logic signed [PROD_W-1:0] man_x;
    logic signed [PROD_W-1:0] prod;

    assign sel   = slot[gain_sel];
    assign sh    = shift_of(sel.expo);
    assign err_x = PROD_W'(err);
    assign man_x = PROD_W'({1'b0, sel.mant});
    assign prod  = err_x * man_x;

    // logarithmic arithmetic shifter, one stage per exponent bit
    logic signed [PROD_W-1:0] stage [EXP_W+1];
    assign stage[0] = prod;

    for (genvar k = 0; k < EXP_W; k++) begin : g_shift
        assign stage[k+1] = sh[k] ? (stage[k] >>> (1 << k)) : stage[k];
    end

    assign delta = OUT_W'(stage[EXP_W]);

endmodule

// File: rtl/agc_accum.sv
module agc_accum
    import agc_pkg::*;
#(
    parameter int ACC_W = 20,
    localparam int SUM_W = ACC_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  acc_op_t                 op,
    input  logic signed [SUM_W-1:0] delta,
    input  logic [ACC_W-1:0]        lim_hi,
    input  logic [ACC_W-1:0]        lim_lo,
    output logic [ACC_W-1:0]        acc
);

    logic [ACC_W-1:0]        acc_q;
    logic [ACC_W-1:0]        acc_nxt;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] hi_x;
    logic signed [SUM_W-1:0] lo_x;

    assign sum  = $signed({2'b00, acc_q}) + delta;
    assign hi_x = $signed({2'b00, lim_hi});
    assign lo_x = $signed({2'b00, lim_lo});

    always_comb begin
        if (sum > hi_x) begin
            acc_nxt = lim_hi;
        end else if (sum < lo_x) begin
            acc_nxt = lim_lo;
        end else begin
            acc_nxt = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            unique case (op)
                ACC_CLEAR: acc_q <= '0;
                ACC_LOAD:  acc_q <= acc_nxt;
                default:   acc_q <= acc_q;
            endcase
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/agc_loop_filter.sv
module agc_loop_filter
    import agc_pkg::*;
#(
    parameter int MAG_W = 12,
    parameter int ACC_W = 20,
    localparam int ERR_W = MAG_W + 1,
    localparam int LGS_W = NUM_GAINS * LG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_clr,
    input  logic             soft_clr,
    input  logic             soft_clr_keep,
    input  logic             median_mode,
    input  logic             gain_sel,
    input  logic [LGS_W-1:0] loop_gains,
    input  logic [MAG_W-1:0] threshold,
    input  logic [ACC_W-1:0] gain_hi,
    input  logic [ACC_W-1:0] gain_lo,
    input  logic             mag_valid,
    input  logic [MAG_W-1:0] mag,
    output logic [ACC_W-1:0] gain_out
);

    settle_mode_t            mode;
    logic signed [ERR_W-1:0] err;
    logic signed [ACC_W+1:0] delta;
    logic                    clr;
    acc_op_t                 op;

    assign mode = settle_mode_t'(median_mode);
    assign clr  = sync_clr | (soft_clr & ~soft_clr_keep);

    always_comb begin
        if (clr) begin
            op = ACC_CLEAR;
        end else if (mag_valid) begin
            op = ACC_LOAD;
        end else begin
            op = ACC_HOLD;
        end
    end

    agc_err_gen #(.MAG_W(MAG_W)) u_err (
        .mode (mode),
        .thr  (threshold),
        .mag  (mag),
        .err  (err)
    );

    agc_gain_scale #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_scale (
        .loop_gains (loop_gains),
        .gain_sel   (gain_sel),
        .err        (err),
        .delta      (delta)
    );

    agc_accum #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .delta  (delta),
        .lim_hi (gain_hi),
        .lim_lo (gain_lo),
        .acc    (gain_out)
    );

endmodule

// File: rtl/agc_loop_filter_chk.sv
module agc_loop_filter_chk #(
    parameter int MAG_W = 12,
    parameter int ACC_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_clr,
    input logic             soft_clr,
    input logic             soft_clr_keep,
    input logic             median_mode,
    input logic [ACC_W-1:0] gain_hi,
    input logic [ACC_W-1:0] gain_lo,
    input logic             mag_valid,
    input logic [MAG_W-1:0] threshold,
    input logic [MAG_W-1:0] mag,
    input logic [ACC_W-1:0] gain_out
);

    logic no_clr;
    logic in_lim;
    assign no_clr = !sync_clr && !(soft_clr && !soft_clr_keep);
    assign in_lim = (gain_out >= gain_lo) && (gain_out <= gain_hi);

    // R2: no sample and no clear leaves the gain alone
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!mag_valid && no_clr) |=> $stable(gain_out));

    // R8: sync clear always empties the accumulator
    p_sync_clear_r8: assert property (@(posedge clk) disable iff (rst)
        sync_clr |=> (gain_out == '0));

    // R9: unmasked soft clear empties the accumulator
    p_soft_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (soft_clr && !soft_clr_keep) |=> (gain_out == '0));

    // R7: an update lands inside the limits
    p_within_limits_r7: assert property (@(posedge clk) disable iff (rst)
        (mag_valid && no_clr && (gain_lo <= gain_hi))
        |=> ((gain_out <= $past(gain_hi)) && (gain_out >= $past(gain_lo))));

    // R4: median mode never lowers the gain when mag <= threshold
    p_median_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (median_mode && mag_valid && no_clr && in_lim && (mag <= threshold))
        |=> (gain_out >= $past(gain_out)));

    // R10: median step bounded by 15 * 1024
    p_median_slew_r10: assert property (@(posedge clk) disable iff (rst)
        (median_mode && mag_valid && no_clr && in_lim)
        |=> (($signed({1'b0, gain_out}) - $signed({1'b0, $past(gain_out)}) <= 15360) &&
             ($signed({1'b0, $past(gain_out)}) - $signed({1'b0, gain_out}) <= 15360)));

endmodule

bind agc_loop_filter agc_loop_filter_chk #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sync_clr      (sync_clr),
    .soft_clr      (soft_clr),
    .soft_clr_keep (soft_clr_keep),
    .median_mode   (median_mode),
    .gain_hi       (gain_hi),
    .gain_lo       (gain_lo),
    .mag_valid     (mag_valid),
    .threshold     (threshold),
    .mag           (mag),
    .gain_out      (gain_out)
);

// File: tb/agc_loop_filter_tb.sv
`timescale 1ns/1ps
module agc_loop_filter_tb;

    localparam int MAG_W = 12;
    localparam int ACC_W = 20;
    localparam int ACC_MAX = (1 << ACC_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sync_clr = 1'b0;
    logic             soft_clr = 1'b0;
    logic             soft_clr_keep = 1'b0;
    logic             median_mode = 1'b0;
    logic             gain_sel = 1'b0;
    logic [15:0]      loop_gains = '0;
    logic [MAG_W-1:0] threshold = '0;
    logic [ACC_W-1:0] gain_hi = ACC_W'(ACC_MAX);
    logic [ACC_W-1:0] gain_lo = '0;
    logic             mag_valid = 1'b0;
    logic [MAG_W-1:0] mag = '0;
    logic [ACC_W-1:0] gain_out;

    int checks = 0;
    int fails  = 0;
    int exp_gain = 0;
    bit done = 0;

    always #2 clk = ~clk;

    agc_loop_filter #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_dut (
        .clk(clk), .rst(rst), .sync_clr(sync_clr), .soft_clr(soft_clr),
        .soft_clr_keep(soft_clr_keep), .median_mode(median_mode),
        .gain_sel(gain_sel), .loop_gains(loop_gains), .threshold(threshold),
        .gain_hi(gain_hi), .gain_lo(gain_lo), .mag_valid(mag_valid),
        .mag(mag), .gain_out(gain_out)
    );

    function automatic logic [7:0] lg(input int e, input int m);
        return {4'(e), 4'(m)};
    endfunction

    task automatic ref_step();
        int e_, m_, err, d, s;
        logic [7:0] b;
        if (rst) begin
            exp_gain = 0;
        end else if (sync_clr || (soft_clr && !soft_clr_keep)) begin
            exp_gain = 0;
        end else if (mag_valid) begin
            b  = gain_sel ? loop_gains[15:8] : loop_gains[7:0];
            m_ = int'(b[3:0]);
            e_ = int'(b[7:4]);
            if (median_mode) err = (mag <= threshold) ? 1024 : -1024;
            else             err = int'(threshold) - int'(mag);
            d = (err * m_) >>> (15 - e_);
            s = exp_gain + d;
            if (s > int'(gain_hi))      s = int'(gain_hi);
            else if (s < int'(gain_lo)) s = int'(gain_lo);
            exp_gain = s;
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        ref_step();
        @(negedge clk);
        checks++;
        if (gain_out !== ACC_W'(exp_gain)) begin
            fails++;
            $display("FAIL %s: gain_out=%0d expected=%0d", tag, gain_out, exp_gain);
        end
    endtask

    task automatic expect_val(input string tag, input int v);
        checks++;
        if (gain_out !== ACC_W'(v)) begin
            fails++;
            $display("FAIL %s: gain_out=%0d expected=%0d", tag, gain_out, v);
        end
    endtask

    task automatic sample(input int t, input int m, input string tag);
        threshold = MAG_W'(t); mag = MAG_W'(m); mag_valid = 1'b1;
        tick(tag);
        mag_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        tick("R1"); tick("R1");
        expect_val("R1", 0);
        rst = 1'b0;

        // R3: mean mode, E=15 M=8, positive error 1000 -> +8000 per sample
        loop_gains = {lg(15, 1), lg(15, 8)};
        sample(2000, 1000, "R3");
        expect_val("R3", 8000);
        sample(2000, 1000, "R3");
        expect_val("R3", 16000);
        // R3: negative error -500*8 = -4000
        sample(1000, 1500, "R3");
        expect_val("R3", 12000);

        // R2: idle cycles hold the gain
        threshold = 12'd0; mag = 12'd4000;
        repeat (4) tick("R2");
        expect_val("R2", 12000);

        // R5: gain_sel=1 picks high byte (M=1, E=15): +300
        gain_sel = 1'b1;
        sample(400, 100, "R5");
        expect_val("R5", 12300);
        gain_sel = 1'b0;
        sample(400, 100, "R5");
        expect_val("R5", 14700);

        // R6: E=0 shift by 15; -1*15>>>15 = -1 (floor), +4095*15>>>15 = 1
        loop_gains = {lg(0, 0), lg(0, 15)};
        sample(0, 1, "R6");
        expect_val("R6", 14699);
        sample(4095, 0, "R6");
        expect_val("R6", 14700);
        // R6: M=0 has no effect
        gain_sel = 1'b1;
        sample(4095, 0, "R6");
        expect_val("R6", 14700);
        gain_sel = 1'b0;

        // R4: median mode, equality counts as positive; E=14 M=4 -> +-2048
        median_mode = 1'b1;
        loop_gains = {lg(15, 15), lg(14, 4)};
        sample(700, 700, "R4");
        expect_val("R4", 16748);
        sample(700, 701, "R4");
        expect_val("R4", 14700);
        sample(700, 0, "R4");
        expect_val("R4", 16748);

        // R8: sync clear with valid sample, also with keep set
        soft_clr_keep = 1'b1; sync_clr = 1'b1;
        sample(700, 0, "R8");
        expect_val("R8", 0);
        sync_clr = 1'b0;

        // R10: max median step 15*1024
        gain_sel = 1'b1;
        sample(700, 0, "R10");
        expect_val("R10", 15360);
        sample(0, 700, "R10");
        expect_val("R10", 0);

        // R7: saturate at upper limit
        gain_hi = 20'd40000; gain_lo = 20'd10000;
        sample(5, 0, "R7");
        expect_val("R7", 15360);
        sample(5, 0, "R7");
        sample(5, 0, "R7");
        expect_val("R7", 40000);
        sample(5, 0, "R7");
        expect_val("R7", 40000);
        // R7: saturate at lower limit
        repeat (3) sample(0, 5, "R7");
        expect_val("R7", 10000);

        // R9: soft clear masked by keep, update proceeds
        soft_clr = 1'b1; soft_clr_keep = 1'b1;
        sample(5, 0, "R9");
        expect_val("R9", 25360);
        // R9: soft clear honoured when keep=0
        soft_clr_keep = 1'b0;
        sample(5, 0, "R9");
        expect_val("R9", 0);
        soft_clr = 1'b0;
        gain_hi = ACC_W'(ACC_MAX); gain_lo = '0;

        // mixed randomized phase (R3, R4, R5, R6, R7, R8, R9)
        for (int i = 0; i < 3000; i++) begin
            int lo_v;
            if (i % 200 == 0) begin
                lo_v = $urandom_range(0, 300000);
                gain_lo = ACC_W'(lo_v);
                gain_hi = ACC_W'(lo_v + $urandom_range(0, 700000));
                loop_gains = 16'($urandom);
            end
            median_mode   = ($urandom_range(0, 1) == 1);
            gain_sel      = ($urandom_range(0, 1) == 1);
            sync_clr      = ($urandom_range(0, 99) == 0);
            soft_clr      = ($urandom_range(0, 49) == 0);
            soft_clr_keep = ($urandom_range(0, 1) == 1);
            mag_valid     = ($urandom_range(0, 3) != 0);
            threshold     = MAG_W'($urandom);
            mag           = MAG_W'($urandom);
            tick("R3/mixed");
        end
        sync_clr = 1'b0; soft_clr = 1'b0; mag_valid = 1'b0;
        tick("R2");

        finish_run();
    end

endmodule